// File: doc/BRIEF.md
# DRAM Bank Bring-Up and Reset Strobe Control

This block owns the first moments of a small memory controller with four DRAM banks and four static chip selects. It puts every active-low memory and card strobe into a known level after power-on reset and after a wake from sleep. It holds one enable bit per DRAM bank, written by software. It also provides the boot static-region timing word, whose bus-width bit follows a board strap.

After power-on reset, every strobe is idle-high. A wake pulse is different: it pulls all row and column strobes low so that the DRAMs stay in self-refresh. A bank's strobes are released only when software enables that bank. While a bank is still disabled, a read aimed at it does not reach the DRAM. Instead it starts a CAS-before-RAS refresh on all banks at once, so software can issue the refresh cycles a DRAM needs before its first real access. Reads and writes to enabled banks pass straight through to the downstream access logic.

Top module: `dram_init_ctrl`

## Requirements
- R1: While power-on reset is applied, `ras_n`, `cas_n` and `cs_n` are all ones, `oe_n`, `we_n`, `io_rd_n`, `io_wr_n`, `card_oe_n` and `card_we_n` are 1, and `bank_en` is 0.
- R2: In the cycle after a `wake_rst` pulse, `ras_n` and `cas_n` are all zeros, `bank_en` is 0, and chip selects and the other strobes are high. `wake_rst` takes priority over a register write in the same cycle.
- R3: A write to register address 0 loads `bank_en` from `reg_wdata[3:0]`, with bit b enabling bank b. From the next cycle, the held strobes of every newly enabled bank go high. Held banks that stay disabled keep their strobes low.
- R4: A read accepted for a disabled bank starts a refresh. In the first cycle after acceptance, all `cas_n` bits are 0 and `ras_n` keeps its idle value. In the next two cycles, both `cas_n` and `ras_n` are all zeros. The bank is bits [11:10] of `req_addr`.
- R5: In the cycle after the refresh strobes release, `rsp_valid` is 1 for exactly one cycle with `rsp_rdata` equal to 0. In that cycle the strobes are back at their idle values. `req_ready` returns to 1 in the following cycle.
- R6: `req_ready` is 0 from the cycle after a refresh is accepted up to and including the `rsp_valid` cycle. A request presented then is neither forwarded nor starts a refresh.
- R7: A read or write to an enabled bank, presented while `req_ready` is 1, raises `fwd_valid` in the same cycle, with `fwd_addr` and `fwd_write` equal to the request. It causes no strobe activity and no `rsp_valid`.
- R8: A write to a disabled bank is accepted and dropped: no `fwd_valid`, no strobe activity and no `rsp_valid`.
- R9: After power-on reset or a wake pulse, `boot_cfg` is: recovery field [16:13] = 0xF, burst delay [12:8] = 0x1F, first-access delay [7:3] = 0x1F, bus-width bit [2] = NOT `boot_wide`, and type [1:0] = 0. Until it is written, bit 2 follows the strap.
- R10: A write to register address 1 replaces all of `boot_cfg` with `reg_wdata[16:0]`, including bit 2, which then no longer follows the strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wake_rst | input | 1 | Synchronous one-cycle pulse on exit from sleep |
| boot_wide | input | 1 | Boot bus-width strap |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 bank enables, 1 boot timing |
| reg_wdata | input | 17 | Register write data |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | Bus request is a write |
| req_addr | input | 12 | Bus request address, top two bits pick the bank |
| req_ready | output | 1 | Request accepted this cycle when valid |
| fwd_valid | output | 1 | Request passed to the access logic |
| fwd_write | output | 1 | Forwarded request direction |
| fwd_addr | output | 12 | Forwarded request address |
| rsp_valid | output | 1 | Completion pulse of a refresh-triggering read |
| rsp_rdata | output | 32 | Read data for that completion, always zero |
| bank_en | output | 4 | Current bank enable bits |
| boot_cfg | output | 17 | Boot static-region timing word |
| ras_n | output | 4 | Row strobes, active low |
| cas_n | output | 4 | Column strobes, active low |
| cs_n | output | 4 | Static chip selects, active low |
| oe_n | output | 1 | Memory output enable, active low |
| we_n | output | 1 | Memory write enable, active low |
| io_rd_n | output | 1 | Card IO read strobe, active low |
| io_wr_n | output | 1 | Card IO write strobe, active low |
| card_oe_n | output | 1 | Card memory output enable, active low |
| card_we_n | output | 1 | Card memory write enable, active low |

## Verification
A lost or wrong hold bit shows up on `ras_n` or `cas_n` in the first cycle after a wake pulse or after an enable write. A stale enable bit shows up in the same cycle as the next request, which is forwarded when it should have started a refresh, or the reverse. A sequencer that leaves its state early or late breaks the lead-one, low-two timing of the strobes within four cycles of acceptance. It also moves the zero-data completion pulse. A mis-reset timing word is visible on `boot_cfg` one cycle after the wake pulse.

// File: rtl/dinit_pkg.sv
package dinit_pkg;

  localparam int unsigned CFG_W   = 17;
  localparam int unsigned REG_AW  = 2;

  localparam logic [REG_AW-1:0] REG_BANK_EN = 2'd0;
  localparam logic [REG_AW-1:0] REG_BOOT    = 2'd1;

  typedef struct packed {
    logic [3:0] recov;
    logic [4:0] burst_dly;
    logic [4:0] first_dly;
    logic       bus_wide;
    logic [1:0] kind;
  } boot_cfg_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LEAD,
    SEQ_BOTH,
    SEQ_DONE
  } seq_state_e;

  function automatic boot_cfg_t boot_default(input logic strap_wide);
    boot_cfg_t c;
    c.recov     = 4'hF;
    c.burst_dly = 5'h1F;
    c.first_dly = 5'h1F;
    c.bus_wide  = ~strap_wide;
    c.kind      = 2'd0;
    return c;
  endfunction

endpackage

// File: rtl/dinit_regs.sv
module dinit_regs
  import dinit_pkg::*;
#(
  parameter int unsigned NBANK = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wake,
  input  logic               strap_wide,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [CFG_W-1:0]   wr_data,
  output logic [NBANK-1:0]   en_o,
  output logic [NBANK-1:0]   hold_o,
  output logic [CFG_W-1:0]   cfg_o
);

  logic [NBANK-1:0] en_q, en_d;
  logic [NBANK-1:0] hold_q, hold_d;
  boot_cfg_t        cfg_q, cfg_d;
  logic             bwset_q, bwset_d;
  logic             upd;
  boot_cfg_t        cfg_view;

  assign upd = wake | wr_en;

  always_comb begin
    en_d    = en_q;
    hold_d  = hold_q;
    cfg_d   = cfg_q;
    bwset_d = bwset_q;
    if (wake) begin
      en_d    = '0;
      hold_d  = '1;
      cfg_d   = boot_default(1'b1);
      bwset_d = 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_BANK_EN: begin
          en_d   = wr_data[NBANK-1:0];
          hold_d = hold_q & ~wr_data[NBANK-1:0];
        end
        REG_BOOT: begin
          cfg_d   = boot_cfg_t'(wr_data);
          bwset_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      hold_q  <= '0;
      cfg_q   <= boot_default(1'b1);
      bwset_q <= 1'b0;
    end else if (upd) begin
      en_q    <= en_d;
      hold_q  <= hold_d;
      cfg_q   <= cfg_d;
      bwset_q <= bwset_d;
    end
  end

  always_comb begin
    cfg_view = cfg_q;
    if (!bwset_q) cfg_view.bus_wide = ~strap_wide;
  end

  assign en_o   = en_q;
  assign hold_o = hold_q;
  assign cfg_o  = cfg_view;

endmodule

// File: rtl/dinit_cbr_seq.sv
module dinit_cbr_seq
  import dinit_pkg::*;
#(
  parameter int unsigned RAS_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic start,
  output logic busy,
  output logic cas_act,
  output logic ras_act,
  output logic done
);

  localparam int unsigned CW = $clog2(RAS_CYC) + 1;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;

  assign adv = wake | start | (state_q != SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_IDLE: begin
        cnt_d = '0;
        if (start) state_d = SEQ_LEAD;
      end
      SEQ_LEAD: state_d = SEQ_BOTH;
      SEQ_BOTH: begin
        if (cnt_q == CW'(RAS_CYC - 1)) begin
          state_d = SEQ_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_DONE: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
    if (wake) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (adv) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy    = (state_q != SEQ_IDLE);
  assign cas_act = (state_q == SEQ_LEAD) || (state_q == SEQ_BOTH);
  assign ras_act = (state_q == SEQ_BOTH);
  assign done    = (state_q == SEQ_DONE);

endmodule

// File: rtl/dinit_pins.sv
module dinit_pins #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned NCS   = 4
) (
  input  logic [NBANK-1:0] hold,
  input  logic             cas_act,
  input  logic             ras_act,
  output logic [NBANK-1:0] ras_n,
  output logic [NBANK-1:0] cas_n,
  output logic [NCS-1:0]   cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             io_rd_n,
  output logic             io_wr_n,
  output logic             card_oe_n,
  output logic             card_we_n
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign ras_n[b] = ~(hold[b] | ras_act);
    assign cas_n[b] = ~(hold[b] | cas_act);
  end

  assign cs_n      = '1;
  assign oe_n      = 1'b1;
  assign we_n      = 1'b1;
  assign io_rd_n   = 1'b1;
  assign io_wr_n   = 1'b1;
  assign card_oe_n = 1'b1;
  assign card_we_n = 1'b1;

endmodule

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
  import dinit_pkg::*;
#(
  parameter int unsigned NBANK   = 4,
  parameter int unsigned NCS     = 4,
  parameter int unsigned AW      = 12,
  parameter int unsigned DW      = 32,
  parameter int unsigned RAS_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wake_rst,
  input  logic                    boot_wide,
  input  logic                    reg_we,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic [CFG_W-1:0]        reg_wdata,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  output logic                    req_ready,
  output logic                    fwd_valid,
  output logic                    fwd_write,
  output logic [AW-1:0]           fwd_addr,
  output logic                    rsp_valid,
  output logic [DW-1:0]           rsp_rdata,
  output logic [NBANK-1:0]        bank_en,
  output logic [CFG_W-1:0]        boot_cfg,
  output logic [NBANK-1:0]        ras_n,
  output logic [NBANK-1:0]        cas_n,
  output logic [NCS-1:0]          cs_n,
  output logic                    oe_n,
  output logic                    we_n,
  output logic                    io_rd_n,
  output logic                    io_wr_n,
  output logic                    card_oe_n,
  output logic                    card_we_n
);

  localparam int unsigned BSEL_W = $clog2(NBANK);

  logic              rst_meta, rst_sync;
  logic [NBANK-1:0]  hold;
  logic              busy, cas_act, ras_act, seq_done;
  logic [BSEL_W-1:0] bank_sel;
  logic              hit_en, accept, cbr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign bank_sel  = req_addr[AW-1 -: BSEL_W];
  assign hit_en    = bank_en[bank_sel];
  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign cbr_start = accept & ~req_write & ~hit_en;

  assign fwd_valid = accept & hit_en;
  assign fwd_write = req_write;
  assign fwd_addr  = req_addr;
  assign rsp_valid = seq_done;
  assign rsp_rdata = '0;

  dinit_regs #(.NBANK(NBANK)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync),
    .wake       (wake_rst),
    .strap_wide (boot_wide),
    .wr_en      (reg_we),
    .wr_addr    (reg_addr),
    .wr_data    (reg_wdata),
    .en_o       (bank_en),
    .hold_o     (hold),
    .cfg_o      (boot_cfg)
  );

  dinit_cbr_seq #(.RAS_CYC(RAS_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync),
    .wake    (wake_rst),
    .start   (cbr_start),
    .busy    (busy),
    .cas_act (cas_act),
    .ras_act (ras_act),
    .done    (seq_done)
  );

  dinit_pins #(.NBANK(NBANK), .NCS(NCS)) u_pins (
    .hold      (hold),
    .cas_act   (cas_act),
    .ras_act   (ras_act),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n),
    .card_oe_n (card_oe_n),
    .card_we_n (card_we_n)
  );

endmodule

// File: rtl/dram_init_chk.sv
module dram_init_chk #(
  parameter int unsigned NBANK  = 4,
  parameter int unsigned BSEL_W = 2,
  parameter int unsigned DW     = 32,
  parameter int unsigned CFG_W  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_rst,
  input logic              boot_wide,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_ready,
  input logic [BSEL_W-1:0] bank_sel,
  input logic [NBANK-1:0]  bank_en,
  input logic              fwd_valid,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_rdata,
  input logic [NBANK-1:0]  ras_n,
  input logic [NBANK-1:0]  cas_n,
  input logic [CFG_W-1:0]  boot_cfg
);

  // R2: wake forces held strobes and cleared enables
  assert_wake_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> (bank_en == '0 && ras_n == '0 && cas_n == '0));

  // R4: read to a disabled bank starts with column strobes leading
  assert_cbr_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !bank_en[bank_sel] && !wake_rst)
      |=> (cas_n == '0 && !req_ready));

  // R5: completion carries zero data
  assert_rsp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata == '0));

  // R5: ready comes back right after completion
  assert_ready_after_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  // R6: no acceptance while the completion is pending
  assert_rsp_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && !fwd_valid));

  // R7: only enabled banks are forwarded
  assert_fwd_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> bank_en[bank_sel]);

  // R9: boot timing word restored by wake
  assert_boot_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> (boot_cfg == {4'hF, 5'h1F, 5'h1F, ~boot_wide, 2'b00}));

endmodule

bind dram_init_ctrl dram_init_chk #(
  .NBANK  (NBANK),
  .BSEL_W (BSEL_W),
  .DW     (DW),
  .CFG_W  (dinit_pkg::CFG_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync),
  .wake_rst  (wake_rst),
  .boot_wide (boot_wide),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_ready (req_ready),
  .bank_sel  (bank_sel),
  .bank_en   (bank_en),
  .fwd_valid (fwd_valid),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .boot_cfg  (boot_cfg)
);

// File: tb/test_dram_init_ctrl.sv
`timescale 1ns/1ps
module test_dram_init_ctrl;

  logic        clk;
  logic        rst_n;
  logic        wake_rst;
  logic        boot_wide;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [16:0] reg_wdata;
  logic        req_valid;
  logic        req_write;
  logic [11:0] req_addr;
  logic        req_ready;
  logic        fwd_valid;
  logic        fwd_write;
  logic [11:0] fwd_addr;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  bank_en;
  logic [16:0] boot_cfg;
  logic [3:0]  ras_n, cas_n, cs_n;
  logic        oe_n, we_n, io_rd_n, io_wr_n, card_oe_n, card_we_n;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  dram_init_ctrl i_dram_init_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_rst(wake_rst), .boot_wide(boot_wide),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
    .fwd_addr(fwd_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bank_en(bank_en), .boot_cfg(boot_cfg), .ras_n(ras_n), .cas_n(cas_n),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic statics_high(input string req);
    chk(req, {cs_n, oe_n, we_n, io_rd_n, io_wr_n, card_oe_n, card_we_n}, 10'h3FF);
  endtask

  task automatic wr(input logic [1:0] a, input logic [16:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  function automatic logic [16:0] cfg_default(input logic strap);
    return {4'hF, 5'h1F, 5'h1F, ~strap, 2'b00};
  endfunction

  // read to a disabled bank: full refresh sequence
  task automatic cbr_read(input logic [11:0] a);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    chk("R4 no forward", fwd_valid, 0);
    chk("R4 ready at start", req_ready, 1);
    tick();
    req_valid = 1'b0;
    chk("R4 lead cas", cas_n, 4'h0);
    chk("R4 lead ras idle", ras_n, 4'hF);
    chk("R6 stall lead", req_ready, 0);
    for (int k = 0; k < 2; k++) begin
      tick();
      chk("R4 both cas", cas_n, 4'h0);
      chk("R4 both ras", ras_n, 4'h0);
      chk("R6 stall both", req_ready, 0);
    end
    tick();
    chk("R5 rsp pulse", rsp_valid, 1);
    chk("R5 rsp zero", rsp_rdata, 0);
    chk("R5 strobes idle", {ras_n, cas_n}, 8'hFF);
    chk("R6 stall done", req_ready, 0);
    tick();
    chk("R5 ready back", req_ready, 1);
    chk("R5 single pulse", rsp_valid, 0);
  endtask

  task automatic quiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      chk(req, {ras_n, cas_n, req_ready, rsp_valid}, 10'h3FE);
      tick();
    end
  endtask

  initial begin
    rst_n = 1'b0; wake_rst = 1'b0; boot_wide = 1'b1; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 ras", ras_n, 4'hF);
    chk("R1 cas", cas_n, 4'hF);
    chk("R1 bank_en", bank_en, 0);
    statics_high("R1 statics");
    chk("R9 cfg strap1", boot_cfg, cfg_default(1'b1));
    rst_n = 1'b1;
    repeat (4) tick();
    boot_wide = 1'b0;
    #1;
    chk("R9 cfg tracks strap", boot_cfg, cfg_default(1'b0));
    boot_wide = 1'b1;

    // sweep of enable masks x banks x direction
    for (int m = 0; m < 16; m++) begin
      wr(2'd0, 17'(m));
      chk("R3 bank_en", bank_en, m);
      for (int b = 0; b < 4; b++) begin
        for (int w = 0; w < 2; w++) begin
          logic [11:0] a;
          a = {2'(b), 10'((m * 37 + b * 11 + w) & 10'h3FF)};
          if (m[b]) begin
            req_valid = 1'b1; req_write = w[0]; req_addr = a;
            #1;
            chk("R7 fwd valid", fwd_valid, 1);
            chk("R7 fwd addr", fwd_addr, a);
            chk("R7 fwd write", fwd_write, w);
            tick();
            req_valid = 1'b0;
            quiet("R7 no refresh", 2);
          end else if (w == 1) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = a;
            #1;
            chk("R8 no forward", fwd_valid, 0);
            tick();
            req_valid = 1'b0;
            quiet("R8 dropped", 4);
          end else begin
            cbr_read(a);
          end
        end
      end
    end

    // R6: request held during refresh is stalled
    wr(2'd0, 17'h2);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h005;
    tick();
    req_addr = 12'h4A0;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R6 no forward when busy", fwd_valid, 0);
      chk("R6 ready low", req_ready, 0);
      tick();
    end
    #1;
    chk("R6 forwarded after refresh", fwd_valid, 1);
    tick();
    req_valid = 1'b0;
    quiet("R6 no extra refresh", 2);

    // R10 boot config write, R9 restore by wake
    wr(2'd1, 17'h0ABC8);
    chk("R10 cfg written", boot_cfg, 17'h0ABC8);
    boot_wide = 1'b0;
    #1;
    chk("R10 strap ignored", boot_cfg, 17'h0ABC8);
    boot_wide = 1'b1;

    // R2/R3 wake sweep
    for (int m = 0; m < 16; m++) begin
      wr(2'd0, 17'hF);
      wake_rst = 1'b1;
      reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 17'hF;
      tick();
      wake_rst = 1'b0; reg_we = 1'b0;
      chk("R2 ras held", ras_n, 4'h0);
      chk("R2 cas held", cas_n, 4'h0);
      chk("R2 bank_en", bank_en, 0);
      statics_high("R2 statics");
      chk("R9 cfg after wake", boot_cfg, cfg_default(1'b1));
      wr(2'd0, 17'(m));
      chk("R3 ras release", ras_n, m);
      chk("R3 cas release", cas_n, m);
      tick();
      chk("R3 still held", {ras_n, cas_n}, {4'(m), 4'(m)});
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule